// File: doc/BRIEF.md
# CPU Interrupt Interface with Acknowledge

This block sits between an interrupt distributor and one processor core. The distributor sends one-cycle pend strobes, one bit per interrupt source, and a priority value for every source. The interface keeps a pending bit and an active bit for each source. It picks the best eligible candidate and raises a single request line to the core when that candidate beats the programmable priority threshold.

Software uses a 32-bit register port. A read of the acknowledge register returns the winning ID and moves that source from pending to active in the same access. When nothing can be delivered, the read returns the reserved value 1023, and software keeps reading until it gets a real ID. Writing an ID to the completion register ends the handling of that source so that it can be delivered again.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the enable bit and the threshold are 0, no source is pending or active, `irqReq` is low, and an acknowledge read returns 1023.
- R2: The control register at byte offset 0x00 holds the enable in bit 0 and reads it back there. While the enable is 0, `irqReq` stays low and acknowledge reads return 1023.
- R3: The threshold register at byte offset 0x04 holds 8 bits in [7:0] and reads them back. A candidate is deliverable only if its priority value is strictly lower than the threshold.
- R4: A source is eligible when it is pending and not active. Among eligible sources the lowest priority value wins, and a tie goes to the lowest ID.
- R5: A read at byte offset 0x0C, with a deliverable candidate, returns the candidate's ID in bits [9:0] with all upper bits 0. From the next cycle that source is active and no longer pending.
- R6: When no candidate is deliverable, an acknowledge read returns 1023 and changes no pending or active state.
- R7: A write at byte offset 0x10 with an ID in bits [9:0] clears the active bit of that source. A write naming a source that is not active, or an ID at or above the source count, is ignored.
- R8: An active source is not selected again, even if it is pended again, until it is completed.
- R9: A pend strobe in the same cycle as the acknowledge of that same source leaves the source pending (and active) afterwards.
- R10: `irqReq` is high exactly when the enable is set and a deliverable candidate exists. Reads at unused offsets, and any cycle without a read, give `regRdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendSet | input | NUM_SRC | One-cycle pend strobes from the distributor, one bit per source |
| prioFlat | input | NUM_SRC*PRIO_W | Priority of each source; source i occupies bits [i*PRIO_W +: PRIO_W] |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address; bits [4:2] select the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the same cycle as regRd |
| irqReq | output | 1 | Interrupt request line to the core |

## Verification
Assertions check these on every cycle: an acknowledge makes at most one source active, and the chosen source really becomes active. With no acknowledge and no completion, the active set stays unchanged. A completion of an active source clears it. Clearing the enable or writing a zero threshold drops the request one cycle later. Only the bench scenarios can show the arbitration order, including ties. They also cover the strict threshold boundary, that completions naming idle or out-of-range IDs have no effect, that re-pending an active source does not deliver it again, and the pend-wins rule when a pend strobe meets an acknowledge in the same cycle. The bench compares all of these against a behavioural model on every clock.

// File: rtl/ciif_pkg.sv
package ciif_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  // Word index (byte address bits [4:2]) of each register
  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_PMASK = 3'd1;
  localparam logic [2:0] REG_ACK   = 3'd3;
  localparam logic [2:0] REG_EOI   = 3'd4;

  typedef struct packed {
    logic            ackTake;  // acknowledge read with a deliverable candidate
    logic            eoiDo;    // completion write
    logic [ID_W-1:0] eoiId;    // ID named by the completion write
  } ciif_strobe_t;
endpackage

// File: rtl/ciif_datapath.sv
module ciif_datapath
  import ciif_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pendSet,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  ciif_strobe_t              strb,
  output logic [ID_W-1:0]           bestId,
  output logic [PRIO_W-1:0]         bestPrio,
  output logic                      bestValid
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] activeQ;
  logic [NUM_SRC-1:0] eligible;

  assign eligible = pendQ & ~activeQ;

  // Scan from the top down; "<=" lets a lower ID take over a tie.
  always_comb begin
    bestId    = SPURIOUS_ID;
    bestPrio  = '1;
    bestValid = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (!bestValid || prioFlat[i*PRIO_W +: PRIO_W] <= bestPrio)) begin
        bestValid = 1'b1;
        bestPrio  = prioFlat[i*PRIO_W +: PRIO_W];
        bestId    = ID_W'(i);
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic ackHit;
    logic eoiHit;
    assign ackHit = strb.ackTake && (bestId == ID_W'(g));
    assign eoiHit = strb.eoiDo && (strb.eoiId == ID_W'(g)) && activeQ[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[g]   <= 1'b0;
        activeQ[g] <= 1'b0;
      end else begin
        // a new pend strobe wins over the acknowledge clear
        pendQ[g]   <= (pendQ[g] & ~ackHit) | pendSet[g];
        activeQ[g] <= (activeQ[g] & ~eoiHit) | ackHit;
      end
    end
  end

  // R5: one acknowledge activates at most one source
  p_one_take_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(activeQ & ~$past(activeQ)) <= 1);

  // R5: the acknowledged source is active afterwards
  p_take_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> activeQ[$past(bestId[IDX_W-1:0])]);

  // R6: without acknowledge or completion the active set holds
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ackTake && !strb.eoiDo) |=> (activeQ == $past(activeQ)));

  // R7: completing an active source clears it
  p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiDo && !strb.ackTake && (strb.eoiId < ID_W'(NUM_SRC)) && activeQ[strb.eoiId[IDX_W-1:0]])
      |=> !activeQ[$past(strb.eoiId[IDX_W-1:0])]);
endmodule

// File: rtl/ciif_ctrl.sv
module ciif_ctrl
  import ciif_pkg::*;
#(
  parameter int unsigned PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [4:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic [ID_W-1:0]   bestId,
  input  logic [PRIO_W-1:0] bestPrio,
  input  logic              bestValid,
  output ciif_strobe_t      strb,
  output logic [31:0]       regRdata,
  output logic              irqReq
);
  logic              ctrlEn;
  logic [PRIO_W-1:0] pmask;
  logic              deliver;
  logic [2:0]        wordSel;

  assign wordSel = regAddr[4:2];
  assign deliver = ctrlEn && bestValid && (bestPrio < pmask);
  assign irqReq  = deliver;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn <= 1'b0;
      pmask  <= '0;
    end else if (regWr) begin
      if (wordSel == REG_CTRL)  ctrlEn <= regWdata[0];
      if (wordSel == REG_PMASK) pmask  <= regWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    strb.ackTake = regRd && (wordSel == REG_ACK) && deliver;
    strb.eoiDo   = regWr && (wordSel == REG_EOI);
    strb.eoiId   = regWdata[ID_W-1:0];
  end

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      unique case (wordSel)
        REG_CTRL:  regRdata = {31'd0, ctrlEn};
        REG_PMASK: regRdata = 32'(pmask);
        REG_ACK:   regRdata = 32'(deliver ? bestId : SPURIOUS_ID);
        default:   regRdata = '0;
      endcase
    end
  end

  // R2: clearing the enable silences the request line
  p_disable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wordSel == REG_CTRL && !regWdata[0]) |=> !irqReq);

  // R3: a zero threshold lets nothing through
  p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wordSel == REG_PMASK && regWdata[PRIO_W-1:0] == '0) |=> !irqReq);

  // R6: a spurious answer never acknowledges anything
  p_spur_no_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && wordSel == REG_ACK && regRdata == 32'(SPURIOUS_ID)) |-> !strb.ackTake);
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import ciif_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pendSet,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  logic                      regRd,
  input  logic                      regWr,
  input  logic [4:0]                regAddr,
  input  logic [31:0]               regWdata,
  output logic [31:0]               regRdata,
  output logic                      irqReq
);
  ciif_strobe_t      strb;
  logic [ID_W-1:0]   bestId;
  logic [PRIO_W-1:0] bestPrio;
  logic              bestValid;

  ciif_ctrl #(.PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .bestId(bestId), .bestPrio(bestPrio), .bestValid(bestValid),
    .strb(strb), .regRdata(regRdata), .irqReq(irqReq)
  );

  ciif_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .pendSet(pendSet), .prioFlat(prioFlat), .strb(strb),
    .bestId(bestId), .bestPrio(bestPrio), .bestValid(bestValid)
  );
endmodule

// File: tb/cpu_irq_iface_tb.sv
module cpu_irq_iface_tb;
  localparam int N = 32;
  localparam int PW = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [N-1:0]      pendSet = '0;
  logic [N*PW-1:0]   prioFlat = '0;
  logic              regRd = 1'b0, regWr = 1'b0;
  logic [4:0]        regAddr = '0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              irqReq;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  bit pendM[N];
  bit actM[N];
  bit enM;
  int maskM;
  int prioM[N];

  always #4 clk = ~clk;

  cpu_irq_iface #(.NUM_SRC(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rstN(rstN), .pendSet(pendSet), .prioFlat(prioFlat), .regRd(regRd),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqReq(irqReq)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // best candidate per the rules: lowest priority value, then lowest ID
  function automatic int model_best();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (pendMisc(i) && (b < 0 || prioM[i] < prioM[b])) b = i;
    return b;
  endfunction

  function automatic bit pendMisc(input int i);
    return pendM[i] && !actM[i];
  endfunction

  function automatic bit model_deliv(input int b);
    return enM && b >= 0 && prioM[b] < maskM;
  endfunction

  task automatic cyc(input string tag, input bit rd, input bit wr, input int addr,
                     input int wd, input logic [N-1:0] ps);
    int b;
    bit dv;
    int expRd;
    @(negedge clk);
    regRd = rd; regWr = wr; regAddr = 5'(addr); regWdata = 32'(wd); pendSet = ps;
    for (int i = 0; i < N; i++) prioFlat[i*PW +: PW] = PW'(prioM[i]);
    #1;
    b = model_best();
    dv = model_deliv(b);
    expRd = 0;
    if (rd) begin
      case (addr)
        0: expRd = enM;
        4: expRd = maskM;
        12: expRd = dv ? b : 1023;
        default: expRd = 0;
      endcase
    end
    check(tag, "irqReq", irqReq, dv);
    check(tag, "regRdata", regRdata, expRd);
    @(posedge clk);
    if (wr) begin
      if (addr == 0) enM = wd[0];
      if (addr == 4) maskM = wd & 8'hFF;
      if (addr == 16 && (wd & 1023) < N && actM[wd & 1023]) actM[wd & 1023] = 0;
    end
    if (rd && addr == 12 && dv) begin
      pendM[b] = 0;
      actM[b] = 1;
    end
    for (int i = 0; i < N; i++) if (ps[i]) pendM[i] = 1;
  endtask

  task automatic idle(input string tag);        cyc(tag, 0, 0, 0, 0, '0);  endtask
  task automatic rd(input string tag, input int a); cyc(tag, 1, 0, a, 0, '0); endtask
  task automatic wr(input string tag, input int a, input int d); cyc(tag, 0, 1, a, d, '0); endtask
  task automatic pend(input string tag, input logic [N-1:0] v); cyc(tag, 0, 0, 0, 0, v); endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin pendM[i] = 0; actM[i] = 0; prioM[i] = 8'hA0; end
    enM = 0; maskM = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    rd("R1", 0); rd("R1", 4); rd("R1", 12); idle("R1");

    // R2 disabled: pend but nothing signalled
    wr("R3", 4, 32'hF0); rd("R3", 4);
    prioM[5] = 8'h80;
    pend("R2", 32'h20); idle("R2"); rd("R2", 12); idle("R2");
    wr("R2", 0, 1); rd("R2", 0); idle("R10");

    // R3 threshold boundary
    wr("R3", 4, 8'h80); idle("R3"); rd("R3", 12);
    wr("R3", 4, 8'h81); idle("R3");
    wr("R3", 4, 0); idle("R3");
    wr("R3", 4, 8'hF0); idle("R10");

    // R4 ordering with a tie
    prioM[3] = 8'h40; prioM[9] = 8'h40; prioM[7] = 8'h60;
    pend("R4", (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 7)); idle("R4");
    rd("R4", 12); rd("R4", 12); rd("R5", 12); rd("R5", 12); rd("R6", 12);

    // R8 re-pend while active
    pend("R8", 32'h1 << 3); idle("R8"); rd("R8", 12);

    // R7 completions
    wr("R7", 16, 20); rd("R7", 12);
    wr("R7", 16, 1000); rd("R7", 12);
    wr("R7", 16, 3); idle("R7"); rd("R7", 12);
    for (int i = 0; i < N; i++) wr("R7", 16, i);
    idle("R7");

    // R9 pend strobe meeting the acknowledge of the same source
    pend("R9", 32'h1 << 12); cyc("R9", 1, 0, 12, 0, 32'h1 << 12);
    idle("R9"); rd("R9", 12); wr("R9", 16, 12); idle("R9"); rd("R9", 12);
    wr("R9", 16, 12); idle("R9");

    // R2 disable drops the line
    pend("R2", 32'h1 << 1); wr("R2", 0, 0); idle("R2"); rd("R2", 12); wr("R2", 0, 1);

    // unused offsets
    rd("R10", 8); rd("R10", 20); rd("R10", 28);

    // R10 mixed traffic
    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom_range(0, 99));
      if (k % 97 == 0)
        for (int i = 0; i < N; i++) prioM[i] = int'($urandom_range(0, 15)) * 16;
      if (r < 30) rd("R10", 12);
      else if (r < 50) wr("R10", 16, int'($urandom_range(0, 40)));
      else if (r < 53) wr("R10", 4, int'($urandom_range(0, 255)));
      else if (r < 55) wr("R10", 0, int'($urandom_range(0, 7)) != 0);
      else if (r < 60) cyc("R10", 1, 1, 12, int'($urandom_range(0, 31)), N'($urandom) & N'($urandom));
      else pend("R10", N'($urandom) & N'($urandom) & N'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule